// File: doc/BRIEF.md
# Chain Readback Frame Parser

This block sits behind the serial link of a stacked battery-monitor chain and interprets the 32-bit frames that the chain shifts back to the host. A separate checker computes the integrity code of each frame and presents a single pass flag next to it. This parser only splits fields, compares addresses, counts frames and decides when a scan ends.

A scan is opened by a one-cycle `start` pulse, and `scan_mode` picks one of three kinds of scan:

- **Enumeration:** counts the devices that answer, verifying that each one reports the expected position.
- **Conversion:** delivers each channel result and keeps a running total of the cell-voltage results.
- **Register readback:** confirms that a single returned byte belongs to the requested device and register.

Device addresses arrive with their bit order reversed, and the parser restores them before any comparison. Error flags are sticky until the next `start`. Frames that arrive while no scan is open are dropped.

Top module: `rbp_frame_parser`

## Requirements
- R1: After reset, `slave_cnt`, `cell_sum`, every pulse output and every error flag are 0.
- R2: The 5-bit device address occupies frame bits [31:27] with address bit 0 in frame bit 31 and address bit 4 in frame bit 27. `chan_dev` reports the restored address.
- R3: In enumeration (`scan_mode`=0), the k-th frame after `start` (k counting from 0) must carry address k. An all-zero frame at position k≥1 ends the scan, sets `slave_cnt` to k-1 and pulses `enum_done` in the cycle after that frame.
- R4: In enumeration, a non-zero frame that passes the check but carries the wrong address sets `addr_err` and closes the scan. A later all-zero frame then gives no `enum_done` and leaves `slave_cnt` unchanged.
- R5: In enumeration, `chain_fault` is set by an all-zero frame at position 0. It is also set by a valid, correctly addressed non-zero frame at position MAX_DEV (default 8). Either case closes the scan and leaves `slave_cnt` unchanged.
- R6: In conversion (`scan_mode`=1), each frame that passes the check produces a one-cycle `chan_valid`, with `chan_id` taken from frame bits [26:23] and `chan_data` from bits [22:11].
- R7: `cell_sum` adds `chan_data` only for channels 0 to 5. Channels 6 to 11 leave it unchanged. A conversion `start` clears it.
- R8: After (`slave_cnt`+1)*12 accepted frames, `scan_done` pulses together with the last `chan_valid` and the scan closes. Further frames produce no `chan_valid`.
- R9: A frame with `crc_ok` low sets the sticky `crc_err` and closes the scan, and produces no `chan_valid`, no `reg_valid` and no change of `cell_sum`. In enumeration this applies only to non-zero frames; an all-zero frame ends the scan regardless of `crc_ok`.
- R10: In register readback (`scan_mode`=2), `req_dev` and `req_reg` are captured at `start`. The next frame that passes the check pulses `reg_valid` with `reg_data` = bits [20:13] if its address equals `req_dev` and bits [26:21] equal `req_reg`; otherwise `addr_err` is set.
- R11: `start` clears `crc_err`, `addr_err` and `chain_fault`, and a frame in the same cycle as `start` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Opens a scan of the kind given by `scan_mode` |
| scan_mode | input | 2 | 0 enumeration, 1 conversion, 2 register readback |
| req_dev | input | 5 | Expected device address for register readback |
| req_reg | input | 6 | Expected register address for register readback |
| frame_valid | input | 1 | A frame is presented this cycle |
| frame | input | 32 | Returned frame |
| crc_ok | input | 1 | Integrity check of `frame` passed |
| slave_cnt | output | 3 | Devices behind the first one, from the last good enumeration |
| enum_done | output | 1 | Enumeration ended on an all-zero frame |
| chan_valid | output | 1 | Conversion result presented |
| chan_dev | output | 5 | Restored device address of the result |
| chan_id | output | 4 | Channel number of the result |
| chan_data | output | 12 | Conversion result |
| cell_sum | output | 18 | Running sum of cell channels |
| scan_done | output | 1 | Full conversion scan received |
| reg_valid | output | 1 | Register byte accepted |
| reg_data | output | 8 | Register byte |
| crc_err | output | 1 | Sticky check failure |
| addr_err | output | 1 | Sticky address mismatch |
| chain_fault | output | 1 | Sticky enumeration overrun or empty chain |

## Verification
Conversion is driven from a vector table that visits all twelve channel numbers. The table includes full-scale and zero results and non-palindromic device addresses, which separates cell from auxiliary accumulation and exposes field slicing or bit-reversal errors.

A three-device chain then runs 36 frames, so that a wrong frame target shows as an early or missing `scan_done`. Enumeration is tried under four conditions:

- a clean chain;
- a skipped address;
- a nine-device overrun;
- an empty chain.

These separate the termination rules from each other. A check failure in mid-scan, a register reply with a wrong register or a wrong device, and frames arriving after a scan has closed show that the sum freezes, that both fields are compared, and that idle frames are dropped.

// File: rtl/rbp_pkg.sv
package rbp_pkg;
  // Frame layout of the returned 32-bit word.
  localparam int FRAME_W  = 32;
  localparam int DEV_W    = 5;
  localparam int CHAN_W   = 4;
  localparam int DATA_W   = 12;
  localparam int RADDR_W  = 6;
  localparam int RDATA_W  = 8;
  localparam int DEV_LSB  = FRAME_W - DEV_W;        // 27
  localparam int CHAN_LSB = DEV_LSB - CHAN_W;       // 23
  localparam int DATA_LSB = CHAN_LSB - DATA_W;      // 11
  localparam int RADDR_LSB = DEV_LSB - RADDR_W;     // 21
  localparam int RDATA_LSB = RADDR_LSB - RDATA_W;   // 13

  typedef enum logic [1:0] {
    SCAN_ENUM = 2'd0,
    SCAN_CONV = 2'd1,
    SCAN_REG  = 2'd2
  } scan_mode_t;
endpackage

// File: rtl/rbp_fields.sv
module rbp_fields
  import rbp_pkg::*;
(
  input  logic [FRAME_W-1:0] frame,
  output logic [DEV_W-1:0]   dev_addr,
  output logic [CHAN_W-1:0]  chan,
  output logic [DATA_W-1:0]  conv_data,
  output logic [RADDR_W-1:0] reg_addr,
  output logic [RDATA_W-1:0] reg_byte,
  output logic               all_zero
);
  // Address travels least significant bit first: restore it.
  for (genvar gi = 0; gi < DEV_W; gi++) begin : g_rev
    assign dev_addr[gi] = frame[FRAME_W-1-gi];
  end

  assign chan      = frame[CHAN_LSB +: CHAN_W];
  assign conv_data = frame[DATA_LSB +: DATA_W];
  assign reg_addr  = frame[RADDR_LSB +: RADDR_W];
  assign reg_byte  = frame[RDATA_LSB +: RDATA_W];
  assign all_zero  = (frame == '0);
endmodule

// File: rtl/rbp_enum_scan.sv
module rbp_enum_scan
  import rbp_pkg::*;
#(
  parameter int MAX_DEV = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic                       sel,
  input  logic                       frame_valid,
  input  logic                       crc_ok,
  input  logic                       all_zero,
  input  logic [DEV_W-1:0]           dev_addr,
  output logic [$clog2(MAX_DEV)-1:0] slave_cnt,
  output logic                       done,
  output logic                       crc_evt,
  output logic                       addr_evt,
  output logic                       fault_evt
);
  localparam int IDX_W = $clog2(MAX_DEV + 1);
  localparam int SLV_W = $clog2(MAX_DEV);

  logic             busy;
  logic [IDX_W-1:0] idx;
  logic             take, good_nz, zero_end, at_limit, idx_zero;

  assign take      = busy && frame_valid && !start;
  assign idx_zero  = (idx == '0);
  assign at_limit  = (idx == IDX_W'(MAX_DEV));
  assign good_nz   = take && !all_zero && crc_ok;
  assign crc_evt   = take && !all_zero && !crc_ok;
  assign addr_evt  = good_nz && (dev_addr != DEV_W'(idx));
  assign fault_evt = (take && all_zero && idx_zero) ||
                     (good_nz && (dev_addr == DEV_W'(idx)) && at_limit);
  assign zero_end  = take && all_zero && !idx_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      idx       <= '0;
      slave_cnt <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy <= sel;
        idx  <= '0;
      end else if (take) begin
        if (zero_end) begin
          slave_cnt <= SLV_W'(idx - 1'b1);
          done      <= 1'b1;
          busy      <= 1'b0;
        end else if (crc_evt || addr_evt || fault_evt) begin
          busy <= 1'b0;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rbp_conv_scan.sv
module rbp_conv_scan
  import rbp_pkg::*;
#(
  parameter int MAX_DEV       = 8,
  parameter int CHANS_PER_DEV = 12,
  parameter int CELL_CHANS    = 6,
  parameter int SUM_W         = 18
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic                       sel,
  input  logic                       frame_valid,
  input  logic                       crc_ok,
  input  logic [$clog2(MAX_DEV)-1:0] slave_cnt,
  input  logic [DEV_W-1:0]           dev_addr,
  input  logic [CHAN_W-1:0]          chan,
  input  logic [DATA_W-1:0]          conv_data,
  output logic                       chan_valid,
  output logic [DEV_W-1:0]           chan_dev,
  output logic [CHAN_W-1:0]          chan_id,
  output logic [DATA_W-1:0]          chan_data,
  output logic [SUM_W-1:0]           cell_sum,
  output logic                       done,
  output logic                       crc_evt
);
  localparam int CNT_W = $clog2(MAX_DEV * CHANS_PER_DEV + 1);

  logic             busy;
  logic [CNT_W-1:0] cnt, target, cnt_nxt;
  logic             take, good, is_cell;

  assign target  = (CNT_W'(slave_cnt) + 1'b1) * CNT_W'(CHANS_PER_DEV);
  assign take    = busy && frame_valid && !start;
  assign good    = take && crc_ok;
  assign crc_evt = take && !crc_ok;
  assign is_cell = (chan < CHAN_W'(CELL_CHANS));
  assign cnt_nxt = cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      cnt        <= '0;
      cell_sum   <= '0;
      chan_valid <= 1'b0;
      chan_dev   <= '0;
      chan_id    <= '0;
      chan_data  <= '0;
      done       <= 1'b0;
    end else begin
      chan_valid <= 1'b0;
      done       <= 1'b0;
      if (start) begin
        busy <= sel;
        cnt  <= '0;
        if (sel) cell_sum <= '0;
      end else if (good) begin
        chan_valid <= 1'b1;
        chan_dev   <= dev_addr;
        chan_id    <= chan;
        chan_data  <= conv_data;
        cnt        <= cnt_nxt;
        if (is_cell) cell_sum <= cell_sum + SUM_W'(conv_data);
        if (cnt_nxt == target) begin
          done <= 1'b1;
          busy <= 1'b0;
        end
      end else if (crc_evt) begin
        busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rbp_reg_check.sv
module rbp_reg_check
  import rbp_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               sel,
  input  logic               frame_valid,
  input  logic               crc_ok,
  input  logic [DEV_W-1:0]   req_dev,
  input  logic [RADDR_W-1:0] req_reg,
  input  logic [DEV_W-1:0]   dev_addr,
  input  logic [RADDR_W-1:0] reg_addr,
  input  logic [RDATA_W-1:0] reg_byte,
  output logic               reg_valid,
  output logic [RDATA_W-1:0] reg_data,
  output logic               crc_evt,
  output logic               addr_evt
);
  logic               busy;
  logic [DEV_W-1:0]   want_dev;
  logic [RADDR_W-1:0] want_reg;
  logic               take, match;

  assign take     = busy && frame_valid && !start;
  assign match    = (dev_addr == want_dev) && (reg_addr == want_reg);
  assign crc_evt  = take && !crc_ok;
  assign addr_evt = take && crc_ok && !match;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      want_dev  <= '0;
      want_reg  <= '0;
      reg_valid <= 1'b0;
      reg_data  <= '0;
    end else begin
      reg_valid <= 1'b0;
      if (start) begin
        busy     <= sel;
        want_dev <= req_dev;
        want_reg <= req_reg;
      end else if (take) begin
        busy <= 1'b0;
        if (crc_ok && match) begin
          reg_valid <= 1'b1;
          reg_data  <= reg_byte;
        end
      end
    end
  end
endmodule

// File: rtl/rbp_frame_parser.sv
module rbp_frame_parser
  import rbp_pkg::*;
#(
  parameter int MAX_DEV       = 8,
  parameter int CHANS_PER_DEV = 12,
  parameter int CELL_CHANS    = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic [1:0]                 scan_mode,
  input  logic [4:0]                 req_dev,
  input  logic [5:0]                 req_reg,
  input  logic                       frame_valid,
  input  logic [31:0]                frame,
  input  logic                       crc_ok,
  output logic [$clog2(MAX_DEV)-1:0] slave_cnt,
  output logic                       enum_done,
  output logic                       chan_valid,
  output logic [4:0]                 chan_dev,
  output logic [3:0]                 chan_id,
  output logic [11:0]                chan_data,
  output logic [$clog2(MAX_DEV*CELL_CHANS*((1<<12)-1)+1)-1:0] cell_sum,
  output logic                       scan_done,
  output logic                       reg_valid,
  output logic [7:0]                 reg_data,
  output logic                       crc_err,
  output logic                       addr_err,
  output logic                       chain_fault
);
  localparam int SUM_W = $clog2(MAX_DEV * CELL_CHANS * ((1 << DATA_W) - 1) + 1);

  logic [DEV_W-1:0]   f_dev;
  logic [CHAN_W-1:0]  f_chan;
  logic [DATA_W-1:0]  f_data;
  logic [RADDR_W-1:0] f_raddr;
  logic [RDATA_W-1:0] f_rbyte;
  logic               f_zero;
  logic sel_enum, sel_conv, sel_reg;
  logic e_crc, e_addr, e_fault, c_crc, r_crc, r_addr;

  assign sel_enum = (scan_mode == SCAN_ENUM);
  assign sel_conv = (scan_mode == SCAN_CONV);
  assign sel_reg  = (scan_mode == SCAN_REG);

  rbp_fields u_fields (
    .frame(frame), .dev_addr(f_dev), .chan(f_chan), .conv_data(f_data),
    .reg_addr(f_raddr), .reg_byte(f_rbyte), .all_zero(f_zero)
  );

  rbp_enum_scan #(.MAX_DEV(MAX_DEV)) u_enum (
    .clk(clk), .rst(rst), .start(start), .sel(sel_enum),
    .frame_valid(frame_valid), .crc_ok(crc_ok), .all_zero(f_zero),
    .dev_addr(f_dev), .slave_cnt(slave_cnt), .done(enum_done),
    .crc_evt(e_crc), .addr_evt(e_addr), .fault_evt(e_fault)
  );

  rbp_conv_scan #(
    .MAX_DEV(MAX_DEV), .CHANS_PER_DEV(CHANS_PER_DEV),
    .CELL_CHANS(CELL_CHANS), .SUM_W(SUM_W)
  ) u_conv (
    .clk(clk), .rst(rst), .start(start), .sel(sel_conv),
    .frame_valid(frame_valid), .crc_ok(crc_ok), .slave_cnt(slave_cnt),
    .dev_addr(f_dev), .chan(f_chan), .conv_data(f_data),
    .chan_valid(chan_valid), .chan_dev(chan_dev), .chan_id(chan_id),
    .chan_data(chan_data), .cell_sum(cell_sum), .done(scan_done),
    .crc_evt(c_crc)
  );

  rbp_reg_check u_reg (
    .clk(clk), .rst(rst), .start(start), .sel(sel_reg),
    .frame_valid(frame_valid), .crc_ok(crc_ok), .req_dev(req_dev),
    .req_reg(req_reg), .dev_addr(f_dev), .reg_addr(f_raddr),
    .reg_byte(f_rbyte), .reg_valid(reg_valid), .reg_data(reg_data),
    .crc_evt(r_crc), .addr_evt(r_addr)
  );

  // Sticky error flags, cleared when a new scan opens.
  always_ff @(posedge clk) begin
    if (rst || start) begin
      crc_err     <= 1'b0;
      addr_err    <= 1'b0;
      chain_fault <= 1'b0;
    end else begin
      crc_err     <= crc_err || e_crc || c_crc || r_crc;
      addr_err    <= addr_err || e_addr || r_addr;
      chain_fault <= chain_fault || e_fault;
    end
  end
endmodule

// File: rtl/rbp_frame_parser_chk.sv
module rbp_frame_parser_chk #(
  parameter int SUM_W = 18
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             enum_done,
  input logic             scan_done,
  input logic             reg_valid,
  input logic             chan_valid,
  input logic             crc_err,
  input logic             addr_err,
  input logic             chain_fault,
  input logic [SUM_W-1:0] cell_sum
);
  a_r3_done_clean: assert property (@(posedge clk) disable iff (rst)
    enum_done |-> !(crc_err || addr_err || chain_fault));

  a_r3_one_result: assert property (@(posedge clk) disable iff (rst)
    $onehot0({enum_done, scan_done, reg_valid}));

  a_r8_done_with_result: assert property (@(posedge clk) disable iff (rst)
    scan_done |-> (chan_valid && !crc_err));

  a_r7_sum_no_decrease: assert property (@(posedge clk) disable iff (rst)
    !start |=> (cell_sum >= $past(cell_sum)));

  a_r9_crc_sticky: assert property (@(posedge clk) disable iff (rst)
    (crc_err && !start) |=> crc_err);

  a_r10_reg_clean: assert property (@(posedge clk) disable iff (rst)
    reg_valid |-> (!addr_err && !crc_err));

  a_r11_start_clears: assert property (@(posedge clk) disable iff (rst)
    start |=> (!crc_err && !addr_err && !chain_fault));
endmodule

bind rbp_frame_parser rbp_frame_parser_chk #(.SUM_W(SUM_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .enum_done(enum_done),
  .scan_done(scan_done), .reg_valid(reg_valid), .chan_valid(chan_valid),
  .crc_err(crc_err), .addr_err(addr_err), .chain_fault(chain_fault),
  .cell_sum(cell_sum)
);

// File: tb/sim_rbp_frame_parser.sv
module sim_rbp_frame_parser;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst, start, frame_valid, crc_ok;
  logic [1:0]  scan_mode;
  logic [4:0]  req_dev;
  logic [5:0]  req_reg;
  logic [31:0] frame;
  logic [2:0]  slave_cnt;
  logic        enum_done, chan_valid, scan_done, reg_valid;
  logic [4:0]  chan_dev;
  logic [3:0]  chan_id;
  logic [11:0] chan_data;
  logic [17:0] cell_sum;
  logic [7:0]  reg_data;
  logic        crc_err, addr_err, chain_fault;

  int checks = 0;
  int errors = 0;

  rbp_frame_parser u0 (
    .clk(clk), .rst(rst), .start(start), .scan_mode(scan_mode),
    .req_dev(req_dev), .req_reg(req_reg), .frame_valid(frame_valid),
    .frame(frame), .crc_ok(crc_ok), .slave_cnt(slave_cnt),
    .enum_done(enum_done), .chan_valid(chan_valid), .chan_dev(chan_dev),
    .chan_id(chan_id), .chan_data(chan_data), .cell_sum(cell_sum),
    .scan_done(scan_done), .reg_valid(reg_valid), .reg_data(reg_data),
    .crc_err(crc_err), .addr_err(addr_err), .chain_fault(chain_fault)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // {device address, channel, result}, one conversion frame per entry
  localparam logic [20:0] VEC [12] = '{
    {5'd0,  4'd0,  12'd1000}, {5'd0,  4'd1,  12'd0},
    {5'd5,  4'd2,  12'hFFF},  {5'd1,  4'd3,  12'd2048},
    {5'd0,  4'd4,  12'd7},    {5'd0,  4'd5,  12'd300},
    {5'd0,  4'd6,  12'd999},  {5'd22, 4'd7,  12'hFFF},
    {5'd0,  4'd8,  12'd1},    {5'd3,  4'd9,  12'd4},
    {5'd0,  4'd10, 12'd5},    {5'd0,  4'd11, 12'd6}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] rev5(input logic [4:0] a);
    logic [4:0] r;
    for (int i = 0; i < 5; i++) r[i] = a[4-i];
    return r;
  endfunction

  function automatic logic [31:0] mkconv(input logic [4:0] d, input logic [3:0] c, input logic [11:0] v);
    return {rev5(d), c, v, 11'h0};
  endfunction

  function automatic logic [31:0] mkreg(input logic [4:0] d, input logic [5:0] ra, input logic [7:0] v);
    return {rev5(d), ra, v, 13'h0};
  endfunction

  function automatic logic [31:0] mkenum(input logic [4:0] d);
    return mkreg(d, 6'h0E, 8'h55);
  endfunction

  task automatic do_start(input logic [1:0] m);
    @(negedge clk);
    start = 1'b1; scan_mode = m;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic send(input logic [31:0] f, input logic ok);
    @(negedge clk);
    frame_valid = 1'b1; frame = f; crc_ok = ok;
    @(negedge clk);
    frame_valid = 1'b0; frame = '0; crc_ok = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [17:0] esum;
    rst = 1'b1; start = 1'b0; scan_mode = 2'd0; req_dev = '0; req_reg = '0;
    frame_valid = 1'b0; frame = '0; crc_ok = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 slave_cnt", 32'(slave_cnt), 0);
    chk("R1 cell_sum", 32'(cell_sum), 0);
    chk("R1 pulses", {enum_done, chan_valid, scan_done, reg_valid}, 0);
    chk("R1 flags", {crc_err, addr_err, chain_fault}, 0);

    // R3 three-device enumeration
    do_start(2'd0);
    send(mkenum(0), 1); send(mkenum(1), 1); send(mkenum(2), 1);
    chk("R3 no early done", 32'(enum_done), 0);
    send(32'h0, 1);
    chk("R3 enum_done", 32'(enum_done), 1);
    chk("R3 slave_cnt", 32'(slave_cnt), 2);

    // R5 overrun past MAX_DEV
    do_start(2'd0);
    for (int i = 0; i < 8; i++) send(mkenum(5'(i)), 1);
    chk("R5 no fault at 8", 32'(chain_fault), 0);
    send(mkenum(8), 1);
    chk("R5 overrun fault", 32'(chain_fault), 1);
    chk("R5 no done", 32'(enum_done), 0);
    chk("R5 slave_cnt kept", 32'(slave_cnt), 2);
    // R5 empty chain, R11 start clears chain_fault
    do_start(2'd0);
    chk("R11 fault cleared", 32'(chain_fault), 0);
    send(32'h0, 1);
    chk("R5 empty chain fault", 32'(chain_fault), 1);

    // R4 address mismatch
    do_start(2'd0);
    send(mkenum(0), 1); send(mkenum(2), 1);
    chk("R4 addr_err", 32'(addr_err), 1);
    send(32'h0, 1);
    chk("R4 no done", 32'(enum_done), 0);
    chk("R4 slave_cnt kept", 32'(slave_cnt), 2);

    // R9 enumeration check failure on non-zero frame
    do_start(2'd0);
    send(mkenum(0), 0);
    chk("R9 enum crc_err", 32'(crc_err), 1);

    // single device chain
    do_start(2'd0);
    send(mkenum(0), 1); send(32'h0, 0);
    chk("R9 zero frame ends despite check", 32'(enum_done), 1);
    chk("R3 single slave_cnt", 32'(slave_cnt), 0);

    // R6/R7/R8/R2 vector table
    do_start(2'd1);
    esum = '0;
    for (int i = 0; i < 12; i++) begin
      send(mkconv(VEC[i][20:16], VEC[i][15:12], VEC[i][11:0]), 1);
      if (VEC[i][15:12] < 4'd6) esum = esum + 18'(VEC[i][11:0]);
      chk("R6 chan_valid", 32'(chan_valid), 1);
      chk("R6 chan_id", 32'(chan_id), 32'(VEC[i][15:12]));
      chk("R6 chan_data", 32'(chan_data), 32'(VEC[i][11:0]));
      chk("R2 chan_dev", 32'(chan_dev), 32'(VEC[i][20:16]));
      chk("R7 cell_sum", 32'(cell_sum), 32'(esum));
      chk("R8 scan_done", 32'(scan_done), (i == 11) ? 1 : 0);
    end
    send(mkconv(0, 0, 12'd77), 1);
    chk("R8 frame after done ignored", 32'(chan_valid), 0);
    chk("R8 sum unchanged", 32'(cell_sum), 32'(esum));

    // R9 check failure mid-scan
    do_start(2'd1);
    chk("R7 sum cleared by start", 32'(cell_sum), 0);
    send(mkconv(0, 0, 12'd100), 1);
    send(mkconv(0, 1, 12'd200), 0);
    chk("R9 crc_err", 32'(crc_err), 1);
    chk("R9 no chan_valid", 32'(chan_valid), 0);
    send(mkconv(0, 2, 12'd50), 1);
    chk("R9 stopped", 32'(chan_valid), 0);
    chk("R9 sum frozen", 32'(cell_sum), 100);
    do_start(2'd1);
    chk("R11 crc_err cleared", 32'(crc_err), 0);

    // three-device conversion: 36 frames
    do_start(2'd0);
    send(mkenum(0), 1); send(mkenum(1), 1); send(mkenum(2), 1); send(32'h0, 1);
    do_start(2'd1);
    esum = '0;
    for (int i = 0; i < 36; i++) begin
      send(mkconv(5'(i / 12), 4'(i % 12), 12'((i * 37 + 5) & 12'hFFF)), 1);
      if ((i % 12) < 6) esum = esum + 18'((i * 37 + 5) & 12'hFFF);
      chk("R8 done at 36", 32'(scan_done), (i == 35) ? 1 : 0);
      if (i == 13) chk("R2 chan_dev one", 32'(chan_dev), 1);
    end
    chk("R7 three-device sum", 32'(cell_sum), 32'(esum));

    // R10 register readback
    req_dev = 5'd3; req_reg = 6'h15;
    do_start(2'd2);
    send(mkreg(3, 6'h15, 8'hA5), 1);
    chk("R10 reg_valid", 32'(reg_valid), 1);
    chk("R10 reg_data", 32'(reg_data), 32'hA5);
    chk("R10 no addr_err", 32'(addr_err), 0);
    do_start(2'd2);
    send(mkreg(3, 6'h16, 8'h11), 1);
    chk("R10 reg mismatch", 32'(addr_err), 1);
    chk("R10 no reg_valid", 32'(reg_valid), 0);
    do_start(2'd2);
    chk("R11 addr_err cleared", 32'(addr_err), 0);
    send(mkreg(4, 6'h15, 8'h22), 1);
    chk("R10 dev mismatch", 32'(addr_err), 1);
    do_start(2'd2);
    send(mkreg(3, 6'h15, 8'h33), 0);
    chk("R9 reg crc_err", 32'(crc_err), 1);
    chk("R9 reg no valid", 32'(reg_valid), 0);

    // R11 frame in the start cycle is ignored
    @(negedge clk);
    start = 1'b1; scan_mode = 2'd2; frame_valid = 1'b1; frame = mkreg(3, 6'h15, 8'h44);
    @(negedge clk);
    start = 1'b0; frame_valid = 1'b0; frame = '0;
    chk("R11 start-cycle frame ignored", 32'(reg_valid), 0);
    send(mkreg(3, 6'h15, 8'h66), 1);
    chk("R11 scan still open", 32'(reg_data), 32'h66);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule